// File: doc/BRIEF.md
# Byte-Lane Asynchronous Word Memory Core

This block is a clock-sampled model of a 16-bit asynchronous pseudo-static memory that has separate upper and lower byte enables. A fast internal clock samples the five active-low control pins, the word address and the input half of the data bus. From the sampled pins the block selects one of four modes: deselect, read, output-disabled or write. The bidirectional bus is split into an input vector, an output vector and a per-lane output-enable vector. An SoC-level pad ring or a bus bridge combines these into real tri-state pins.

A write lasts while chip select, write strobe and at least one byte enable are all sampled active. The write is committed into the array once the first sample after that overlap shows it has ended. The address, data and lane mask stored are the ones present at the last sample inside the overlap. Reads drive only the lanes whose byte enable is active. A standby flag reports the two deselect cases. `ADDR_W` sets the logical address width, with a default of 17, which gives 128K words. `ARRAY_AW` sets how many words are physically populated. When `ARRAY_AW` is smaller than `ADDR_W`, address bits fold onto the populated index by XOR. Setting `ARRAY_AW` equal to `ADDR_W` gives the full array.

Top module: `lane_mem_core`

## Requirements
- R1: With chip select (`cs_ni`) sampled high, `dq_oe_o` is 0 and `standby_o` is 1, whatever the other pins are.
- R2: With both byte enables (`ub_ni`, `lb_ni`) sampled high, `dq_oe_o` is 0, `standby_o` is 1, and no write takes place even if chip select and write strobe are low.
- R3: With `cs_ni`=0, `we_ni`=1 and `oe_ni`=0 (read), `dq_oe_o[0]` (bits 7:0) equals the inverse of `lb_ni` and `dq_oe_o[1]` (bits 15:8) equals the inverse of `ub_ni`. Each enabled lane of `dq_o` carries the stored word at `addr_i`.
- R4: With `cs_ni`=0, `we_ni`=1, `oe_ni`=1 and at least one byte enable low, `dq_oe_o` is 0 and `standby_o` is 0 (output-disabled but active).
- R5: With `cs_ni`=0, `we_ni`=0 and at least one byte enable low (write), `dq_oe_o` is 0 and `standby_o` is 0, whatever the level of `oe_ni`.
- R6: A write stores bits 7:0 only if `lb_ni` is low and bits 15:8 only if `ub_ni` is low. A lane whose enable is high keeps its previous contents.
- R7: A write is committed when any one of chip select, write strobe or the byte enables ends the overlap. The address, data and lane mask committed are those at the last sample inside the overlap, so a data change during the write stores the later value.
- R8: Outputs reflect the pins registered at the previous rising clock edge, and a committed word is readable within three cycles after the ending pin change is sampled.
- R9: While `rst_ni` is low, the sampled pins are forced to the deselect state, so `standby_o` is 1 and `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| ub_ni | input | 1 | Upper byte enable (bits 15:8), active low |
| lb_ni | input | 1 | Lower byte enable (bits 7:0), active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 16 | Bus data into the memory |
| dq_o | output | 16 | Bus data out of the memory |
| dq_oe_o | output | 2 | Per-lane output enable, bit 0 for 7:0, bit 1 for 15:8 |
| standby_o | output | 1 | High when deselected |

## Verification
On every cycle, the assertions tie the lane enables and the standby flag to the control pins sampled one edge earlier, across all four modes. They also check that a driven lane never coexists with standby. The stored contents cannot be seen by those properties. The bench's sweeps therefore show the committed data and which lanes were kept: they write with each lane mask, end writes in each of the three ways, change data in mid-write, try a blocked write with both enables high, and read every address back with every enable combination.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL,
    MODE_READ,
    MODE_OUTOFF,
    MODE_WRITE
  } mode_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1};
endpackage

// File: rtl/lane_mem_sampler.sv
module lane_mem_sampler
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ctl_t              ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= CTL_IDLE;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      ctl_o  <= ctl_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/lane_mem_decoder.sv
module lane_mem_decoder
  import lane_mem_pkg::*;
#(
  parameter int LANES = 2
) (
  input  ctl_t             ctl_i,
  output mode_e            mode_o,
  output logic [LANES-1:0] lane_en_o,
  output logic             wr_act_o,
  output logic             standby_o
);
  // lane 0 = lower byte, lane 1 = upper byte
  assign lane_en_o = LANES'({~ctl_i.ub_n, ~ctl_i.lb_n});

  always_comb begin
    if (ctl_i.cs_n || (lane_en_o == '0)) mode_o = MODE_DESEL;
    else if (!ctl_i.we_n)                mode_o = MODE_WRITE;
    else if (!ctl_i.oe_n)                mode_o = MODE_READ;
    else                                 mode_o = MODE_OUTOFF;
  end

  assign wr_act_o  = (mode_o == MODE_WRITE);
  assign standby_o = (mode_o == MODE_DESEL);
endmodule

// File: rtl/lane_mem_wr_track.sv
module lane_mem_wr_track #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  mask_o
);
  logic act_q;

  // hold the latest sample taken inside the write overlap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else begin
      act_q <= wr_act_i;
      if (wr_act_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
        mask_o <= lane_en_i;
      end
    end
  end

  assign commit_o = act_q && !wr_act_i;
endmodule

// File: rtl/lane_mem_array.sv
module lane_mem_array #(
  parameter int ADDR_W   = 17,
  parameter int ARRAY_AW = 10,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ARRAY_AW;

  function automatic logic [ARRAY_AW-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [ARRAY_AW-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) r[i % ARRAY_AW] ^= a[i];
    return r;
  endfunction

  logic [ARRAY_AW-1:0] widx, ridx;
  assign widx = fold(waddr_i);
  assign ridx = fold(raddr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[l]) mem[widx] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[ridx];
  end
endmodule

// File: rtl/lane_mem_core.sv
module lane_mem_core
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int ARRAY_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [1:0]        dq_oe_o,
  output logic              standby_o
);
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  ctl_t              ctl_s;
  logic [ADDR_W-1:0] addr_s, c_addr;
  logic [DATA_W-1:0] data_s, c_data;
  logic [LANES-1:0]  lane_en, c_mask;
  mode_e             mode;
  logic              wr_act, commit;

  lane_mem_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i ('{cs_n: cs_ni, we_n: we_ni, oe_n: oe_ni, ub_n: ub_ni, lb_n: lb_ni}),
    .addr_i(addr_i),
    .data_i(dq_i),
    .ctl_o (ctl_s),
    .addr_o(addr_s),
    .data_o(data_s)
  );

  lane_mem_decoder #(.LANES(LANES)) u_dec (
    .ctl_i    (ctl_s),
    .mode_o   (mode),
    .lane_en_o(lane_en),
    .wr_act_o (wr_act),
    .standby_o(standby_o)
  );

  lane_mem_wr_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_act_i (wr_act),
    .addr_i   (addr_s),
    .data_i   (data_s),
    .lane_en_i(lane_en),
    .commit_o (commit),
    .addr_o   (c_addr),
    .data_o   (c_data),
    .mask_o   (c_mask)
  );

  lane_mem_array #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i  (clk_i),
    .we_i   (commit),
    .mask_i (c_mask),
    .waddr_i(c_addr),
    .wdata_i(c_data),
    .raddr_i(addr_s),
    .rdata_o(dq_o)
  );

  assign dq_oe_o = (mode == MODE_READ) ? lane_en : '0;
endmodule

// File: rtl/lane_mem_core_chk.sv
module lane_mem_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic       ub_ni,
  input logic       lb_ni,
  input logic [1:0] dq_oe_o,
  input logic       standby_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_desel_hiz_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cs_ni) |-> (dq_oe_o == 2'b00) && standby_o);

  p_no_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(ub_ni && lb_ni) |-> (dq_oe_o == 2'b00) && standby_o);

  p_read_lanes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!cs_ni && we_ni && !oe_ni)
    |-> dq_oe_o == {!$past(ub_ni), !$past(lb_ni)});

  p_out_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!cs_ni && we_ni && oe_ni && !(ub_ni && lb_ni))
    |-> (dq_oe_o == 2'b00) && !standby_o);

  p_write_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!cs_ni && !we_ni && !(ub_ni && lb_ni))
    |-> (dq_oe_o == 2'b00) && !standby_o);

  p_drive_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o != 2'b00) |-> !standby_o);
endmodule

bind lane_mem_core lane_mem_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .ub_ni    (ub_ni),
  .lb_ni    (lb_ni),
  .dq_oe_o  (dq_oe_o),
  .standby_o(standby_o)
);

// File: tb/lane_mem_core_tb_top.sv
`timescale 1ns/1ps
module lane_mem_core_tb_top;
  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, ub_ni = 1'b1, lb_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   dq_i = '0;
  logic [15:0]   dq_o;
  logic [1:0]    dq_oe_o;
  logic          standby_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] mdl [WORDS];

  always #2.5 clk_i = ~clk_i;

  lane_mem_core #(.ADDR_W(AW), .ARRAY_AW(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .ub_ni(ub_ni), .lb_ni(lb_ni), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .standby_o(standby_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'b11111;
    step();
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h1357 + k * 16'h0F1D) ^ 16'hA5C3);
  endfunction

  // term: 0 write strobe rises, 1 chip select rises, 2 byte enables rise
  task automatic wr(input int a, input logic [15:0] d, input logic u, input logic l, input int term);
    addr_i = AW'(a); dq_i = d;
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = {3'b001, u, l};
    step(); step();
    case (term)
      0: we_ni = 1'b1;
      1: cs_ni = 1'b1;
      default: {ub_ni, lb_ni} = 2'b11;
    endcase
    dq_i = ~d;
    step(); step(); step();
    idle();
    if (!(u && l)) begin
      if (!l) mdl[a][7:0]  = d[7:0];
      if (!u) mdl[a][15:8] = d[15:8];
    end
  endtask

  task automatic rd(input int a, input logic u, input logic l, input string req);
    addr_i = AW'(a);
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = {3'b010, u, l};
    step();
    chk(dq_oe_o == {~u, ~l}, req, 16'(dq_oe_o), 16'({~u, ~l}));
    if (!l) chk(dq_o[7:0] == mdl[a][7:0], req, dq_o, mdl[a]);
    if (!u) chk(dq_o[15:8] == mdl[a][15:8], req, dq_o, mdl[a]);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R9 reset state
    chk(standby_o && dq_oe_o == 2'b00, "R9", {14'h0, dq_oe_o}, 16'h0);
    rst_ni = 1'b1;
    step(); step();
    chk(standby_o && dq_oe_o == 2'b00, "R1 after reset", 16'(standby_o), 16'h1);

    // R6 R7: fill every word, full width, rotating termination
    for (int a = 0; a < WORDS; a++) wr(a, pat(a, 0), 1'b0, 1'b0, a % 3);
    for (int a = 0; a < WORDS; a++) rd(a, 1'b0, 1'b0, "R7 full write");

    // R6: byte-masked overwrite, lane choice and termination varied
    for (int a = 0; a < WORDS; a++) wr(a, pat(a, 1), (a % 3) == 0, (a % 3) == 1, (a / 3) % 3);
    for (int a = 0; a < WORDS; a++)
      for (int e = 0; e < 3; e++) rd(a, e == 1, e == 2, "R6 R3 masked");

    // R2: overlap without any byte enable stores nothing
    addr_i = 4'd7; dq_i = ~mdl[7];
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'b00011;
    step();
    chk(standby_o && dq_oe_o == 2'b00, "R2", 16'(standby_o), 16'h1);
    step(); idle(); step(); step();
    rd(7, 1'b0, 1'b0, "R2 no write");

    // R7 R5: data changes in mid-write, output enable low throughout
    addr_i = 4'd3; dq_i = 16'h1111;
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'b00000;
    step();
    chk(dq_oe_o == 2'b00 && !standby_o, "R5 oe ignored", 16'(dq_oe_o), 16'h0);
    dq_i = 16'hBEEF; step();
    we_ni = 1'b1; dq_i = 16'h2222;
    step(); step(); step();
    mdl[3] = 16'hBEEF;
    rd(3, 1'b0, 1'b0, "R7 last data");

    // R8: committed word readable three cycles after end is sampled
    addr_i = 4'd9; dq_i = 16'h5A5A;
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'b00100;
    step(); step();
    {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'b01000;
    step(); step(); step();
    mdl[9] = 16'h5A5A;
    chk(dq_o == 16'h5A5A, "R8 latency", dq_o, 16'h5A5A);

    // R1 R2 R3 R4 R5: every control pattern at one word
    for (int c = 0; c < 32; c++) begin
      logic cs, we, oe, u, l;
      logic [1:0] eoe;
      logic esb;
      {cs, we, oe, u, l} = 5'(c);
      addr_i = 4'd5; dq_i = mdl[5];
      {cs_ni, we_ni, oe_ni, ub_ni, lb_ni} = 5'(c);
      step();
      esb = cs || (u && l);
      eoe = (!esb && we && !oe) ? {~u, ~l} : 2'b00;
      chk(standby_o == esb, "R1 R2 R4 R5 standby", 16'(standby_o), 16'(esb));
      chk(dq_oe_o == eoe, "R1 R3 R4 R5 lanes", 16'(dq_oe_o), 16'(eoe));
      if (eoe[0]) chk(dq_o[7:0] == mdl[5][7:0], "R3 data", dq_o, mdl[5]);
      if (eoe[1]) chk(dq_o[15:8] == mdl[5][15:8], "R3 data", dq_o, mdl[5]);
      idle(); step(); step();
    end
    for (int a = 0; a < WORDS; a++) rd(a, 1'b0, 1'b0, "R6 final");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule